// File: doc/BRIEF.md
# Sync Delay Sweep Calibrator

This controller finds a safe receiver delay setting for a synchronization input whose timing against an internal clock edge cannot be observed directly. After a start pulse it first sets the validation-delay register to its minimum. It then tries every receiver delay code from 0 to 31 in ascending order. At each code it runs a fixed number of timing-validation measurements. A measurement sets the validation control bit, clears it again, waits a settle time and then samples a one-bit error flag. The flag passes through a short synchronizer first, because a marginal setting can leave the flag itself metastable.

Each code is graded from its samples. All zero is a stable pass, all one is a stable fail, and anything mixed is intermittent. The grade goes into a 32-entry status memory that can be read after the run. The controller then looks for the first run of passing codes that has a non-passing code on both sides, and takes its midpoint, rounding down. That code is written to the receiver delay register and also shown on an output port, and done is raised. If no bounded run exists, an error flag is set and code 0 is written instead.

Register traffic goes out on a simple write port: an address, a data word and a one-cycle strobe. The serial transport behind that port is not part of this block.

Top module: `syncdly_cal`

## Requirements
- R1: In the cycle that busy rises after a start pulse, the block issues its first write: data 0 to the validation-delay address (default 8'h0A).
- R2: During the sweep, writes to the receiver-delay address (default 8'h0B) carry codes 0, 1, ... 31 in that order, each exactly once. Exactly one further write to that address follows, carrying the result.
- R3: For every code the block makes exactly NSAMP (default 8) measurements. A measurement is a write of 1<<VALDIS_BIT (default bit 5) to the control address (default 8'h01), then a write of 0, then at least SETTLE_CYC cycles before the error flag is sampled.
- R4: Each code is graded 2'b00 when all of its samples are 0, 2'b01 when all are 1, and 2'b10 when they are mixed. The grade for code i appears on stat_cls one clock after i is placed on stat_idx.
- R5: The chosen code is (first + last) >> 1 over the lowest run of consecutive passing codes bounded below and above by non-passing codes. It appears as the data of the final receiver-delay write and on delay_code while done is high.
- R6: A passing run that contains code 0 or code 31 is never chosen.
- R7: When no bounded passing run exists, no_window is 1, delay_code is 0, the final receiver-delay write carries 0, and done still rises.
- R8: busy stays high from the clock after a start pulse until done rises. done stays high until the next start. busy and done are never high together.
- R9: After reset, busy, done, no_window, reg_wr and delay_code are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a calibration while idle |
| err_flag | input | 1 | Sync error flag from the validation circuit (asynchronous) |
| reg_wr | output | 1 | Register write strobe, one cycle per write |
| reg_addr | output | ADDR_W | Register write address |
| reg_data | output | DATA_W | Register write data |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration finished; held until next start |
| no_window | output | 1 | No bounded pass window was found |
| delay_code | output | CODE_W | Chosen receiver delay code |
| stat_idx | input | CODE_W | Status memory read index |
| stat_cls | output | 2 | Grade of the indexed code, one cycle latency |

## Verification
The bench aims at how windows are picked. It covers a passing run that begins at code 0, which a naive search would take as the answer. It covers a run that stretches to code 31, a window one code wide, a window of even length where rounding up would give a result one code too high, and profiles with no window at all, where a faulty design would hang or leave a stale code. Intermittent codes switch their flag between measurements. A tally that kept only the last sample, or that graded on a single sample, would then report them as pass or fail and move the chosen window. The bench also counts every control-bit set/clear pair per code and checks the order of the sweep writes, so a skipped or repeated measurement shows up directly.

// File: rtl/syncdly_cal_pkg.sv
package syncdly_cal_pkg;
  // Per-code grade stored in the status memory
  typedef enum logic [1:0] {
    CLS_PASS  = 2'b00,
    CLS_FAIL  = 2'b01,
    CLS_MIXED = 2'b10
  } cls_e;
endpackage

// File: rtl/sample_tally.sv
// Counts error-flag ones across the measurements of one delay code and grades it.
module sample_tally
  import syncdly_cal_pkg::*;
#(
  parameter int NSAMP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stb,
  input  logic bit_in,
  output cls_e cls
);
  localparam int CNT_W = $clog2(NSAMP + 1);

  logic [CNT_W-1:0] ones;

  always_ff @(posedge clk) begin
    if (rst || clr) ones <= '0;
    else if (stb && bit_in) ones <= ones + CNT_W'(1);
  end

  always_comb begin
    if (ones == '0) cls = CLS_PASS;
    else if (ones == CNT_W'(NSAMP)) cls = CLS_FAIL;
    else cls = CLS_MIXED;
  end

  // R4: the ones count can never pass the number of measurements
  assert_ones_bound_R4: assert property (@(posedge clk) disable iff (rst)
    ones <= CNT_W'(NSAMP));

endmodule

// File: rtl/window_pick.sv
// Tracks passing runs one code at a time and latches the midpoint of the first bounded run.
module window_pick
  import syncdly_cal_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              upd,
  input  cls_e              cls,
  input  logic [CODE_W-1:0] code,
  output logic              found,
  output logic [CODE_W-1:0] pick
);
  logic              in_run;
  logic              run_ok;
  logic [CODE_W-1:0] run_lo;
  logic [CODE_W:0]   sum;

  // run ends at code-1; sum carries one extra bit so nothing is lost
  assign sum = {1'b0, run_lo} + {1'b0, code} - (CODE_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      in_run <= 1'b0;
      run_ok <= 1'b0;
      run_lo <= '0;
      found  <= 1'b0;
      pick   <= '0;
    end else if (upd) begin
      if (cls == CLS_PASS) begin
        if (!in_run) begin
          in_run <= 1'b1;
          run_lo <= code;
          run_ok <= (code != '0);   // a run from code 0 has no lower bound
        end
      end else begin
        if (in_run && run_ok && !found) begin
          found <= 1'b1;
          pick  <= CODE_W'(sum >> 1);
        end
        in_run <= 1'b0;
      end
    end
  end

  // R6: a bounded window never yields an edge code
  assert_pick_interior_R6: assert property (@(posedge clk) disable iff (rst)
    found |-> (pick != '0) && (pick != '1));

  // R5: once found, the choice is not overwritten by later runs
  assert_pick_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (found && !clr) |=> (found && $stable(pick)));

endmodule

// File: rtl/status_ram.sv
// Simple dual-port grade memory, registered read, no reset so block RAM can be inferred.
module status_ram #(
  parameter int AW = 5,
  parameter int W  = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/syncdly_cal.sv
module syncdly_cal
  import syncdly_cal_pkg::*;
#(
  parameter int                CODE_W      = 5,
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter int                NSAMP       = 8,
  parameter int                SETTLE_CYC  = 4,
  parameter int                SYNC_STAGES = 2,
  parameter int                VALDIS_BIT  = 5,
  parameter logic [ADDR_W-1:0] ADDR_VALDLY = 8'h0A,
  parameter logic [ADDR_W-1:0] ADDR_RXDLY  = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_VALDIS = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              err_flag,
  output logic              reg_wr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_data,
  output logic              busy,
  output logic              done,
  output logic              no_window,
  output logic [CODE_W-1:0] delay_code,
  input  logic [CODE_W-1:0] stat_idx,
  output logic [1:0]        stat_cls
);
  localparam int SMP_W = (NSAMP > 1) ? $clog2(NSAMP) : 1;
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CODE_W-1:0] LAST_CODE = '1;
  localparam logic [DATA_W-1:0] DIS_ON = DATA_W'(1) << VALDIS_BIT;

  typedef enum logic [3:0] {
    S_IDLE, S_RXD, S_DIS1, S_DIS0, S_SETTLE, S_SAMP, S_CLASS, S_FINAL, S_DONE
  } st_e;

  st_e               st;
  logic [CODE_W-1:0] code;
  logic [SMP_W-1:0]  smp_i;
  logic [SET_W-1:0]  set_cnt;
  logic [SYNC_STAGES-1:0] err_sr;
  logic              err_s;
  cls_e              cls;
  logic              found;
  logic [CODE_W-1:0] pick;

  // Error flag synchronizer; depth picked by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) err_sr <= err_flag;
    end else begin : g_syncn
      always_ff @(posedge clk) err_sr <= {err_sr[SYNC_STAGES-2:0], err_flag};
    end
  endgenerate
  assign err_s = err_sr[SYNC_STAGES-1];

  sample_tally #(.NSAMP(NSAMP)) u_tally (
    .clk    (clk),
    .rst    (rst),
    .clr    (st == S_RXD),
    .stb    (st == S_SAMP),
    .bit_in (err_s),
    .cls    (cls)
  );

  window_pick #(.CODE_W(CODE_W)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .clr   (st == S_IDLE && start),
    .upd   (st == S_CLASS),
    .cls   (cls),
    .code  (code),
    .found (found),
    .pick  (pick)
  );

  status_ram #(.AW(CODE_W), .W(2)) u_stat (
    .clk   (clk),
    .we    (st == S_CLASS),
    .waddr (code),
    .wdata (cls),
    .raddr (stat_idx),
    .rdata (stat_cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      no_window  <= 1'b0;
      delay_code <= '0;
      reg_wr     <= 1'b0;
      reg_addr   <= '0;
      reg_data   <= '0;
      code       <= '0;
      smp_i      <= '0;
      set_cnt    <= '0;
    end else begin
      reg_wr <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          busy       <= 1'b1;
          done       <= 1'b0;
          no_window  <= 1'b0;
          delay_code <= '0;
          code       <= '0;
          reg_wr     <= 1'b1;
          reg_addr   <= ADDR_VALDLY;
          reg_data   <= '0;
          st         <= S_RXD;
        end
        S_RXD: begin
          reg_wr   <= 1'b1;
          reg_addr <= ADDR_RXDLY;
          reg_data <= DATA_W'(code);
          smp_i    <= '0;
          st       <= S_DIS1;
        end
        S_DIS1: begin
          reg_wr   <= 1'b1;
          reg_addr <= ADDR_VALDIS;
          reg_data <= DIS_ON;
          st       <= S_DIS0;
        end
        S_DIS0: begin
          reg_wr   <= 1'b1;
          reg_addr <= ADDR_VALDIS;
          reg_data <= '0;
          set_cnt  <= '0;
          st       <= S_SETTLE;
        end
        S_SETTLE: begin
          if (set_cnt == SET_W'(SETTLE_CYC - 1)) st <= S_SAMP;
          else set_cnt <= set_cnt + SET_W'(1);
        end
        S_SAMP: begin
          if (smp_i == SMP_W'(NSAMP - 1)) st <= S_CLASS;
          else begin
            smp_i <= smp_i + SMP_W'(1);
            st    <= S_DIS1;
          end
        end
        S_CLASS: begin
          if (code == LAST_CODE) st <= S_FINAL;
          else begin
            code <= code + CODE_W'(1);
            st   <= S_RXD;
          end
        end
        S_FINAL: begin
          reg_wr     <= 1'b1;
          reg_addr   <= ADDR_RXDLY;
          reg_data   <= found ? DATA_W'(pick) : '0;
          delay_code <= found ? pick : '0;
          no_window  <= !found;
          st         <= S_DONE;
        end
        S_DONE: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: the validation-delay clear is the first write of a run
  assert_first_write_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (reg_wr && reg_addr == ADDR_VALDLY && reg_data == '0));

  // R3: a sample is only taken straight after the settle wait
  assert_sample_after_settle_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_SAMP) |-> ($past(st) == S_SETTLE));

  // R7: a missing window leaves the code at zero
  assert_nowin_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (done && no_window) |-> (delay_code == '0));

  // R8: busy and done are exclusive
  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

endmodule

// File: tb/syncdly_cal_bench.sv
module syncdly_cal_bench;
  localparam int NS = 8;
  localparam logic [7:0] A_VDLY = 8'h0A, A_RX = 8'h0B, A_DIS = 8'h01;
  localparam logic [7:0] D_ON = 8'h20;
  localparam logic [1:0] P = 2'b00, F = 2'b01, M = 2'b10;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic err_flag;
  logic reg_wr, busy, done, no_window;
  logic [7:0] reg_addr, reg_data;
  logic [4:0] delay_code, stat_idx;
  logic [1:0] stat_cls;

  always #10 clk = ~clk;  // 50 MHz

  syncdly_cal u_syncdly_cal (
    .clk(clk), .rst(rst), .start(start), .err_flag(err_flag),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
    .busy(busy), .done(done), .no_window(no_window), .delay_code(delay_code),
    .stat_idx(stat_idx), .stat_cls(stat_cls)
  );

  logic [1:0] prof [32];
  int n_chk = 0, n_fail = 0;

  // Bus monitor and flag model
  logic clr_mon = 1'b0;
  logic [4:0] rx_code;
  int meas, rx_wr, pairs, seq_bad, pair_bad, final_data;
  bit dis_pend, vdly_ok;

  assign err_flag = (prof[rx_code] == F) ? 1'b1 :
                    (prof[rx_code] == M) ? meas[0] : 1'b0;

  always @(posedge clk) begin
    if (clr_mon) begin
      rx_code <= '0; meas <= 0; rx_wr <= 0; pairs <= 0; seq_bad <= 0;
      pair_bad <= 0; final_data <= -1; dis_pend <= 0; vdly_ok <= 0;
    end else if (!rst && reg_wr) begin
      if (reg_addr == A_VDLY) vdly_ok <= (reg_data == 8'd0) && (rx_wr == 0);
      else if (reg_addr == A_RX) begin
        if (rx_wr < 32) begin
          if (int'(reg_data) != rx_wr) seq_bad <= seq_bad + 1;
          rx_code <= reg_data[4:0];
        end else final_data <= int'(reg_data);
        if (rx_wr > 0 && pairs != NS) pair_bad <= pair_bad + 1;
        rx_wr <= rx_wr + 1; pairs <= 0; dis_pend <= 0;
      end else if (reg_addr == A_DIS) begin
        if (reg_data == D_ON) begin
          if (dis_pend) pair_bad <= pair_bad + 1;
          dis_pend <= 1;
        end else if (reg_data == 8'd0) begin
          if (!dis_pend) pair_bad <= pair_bad + 1;
          else pairs <= pairs + 1;
          dis_pend <= 0; meas <= meas + 1;
        end else pair_bad <= pair_bad + 1;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: run hung, act=%0d exp=<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // Expected choice, from the window rule alone
  function automatic int exp_pick(output bit nw);
    int s = 0;
    while (s < 32) begin
      if (prof[s] != P) s++;
      else begin
        int e;
        e = s;
        while (e < 31 && prof[e+1] == P) e++;
        if (s > 0 && e < 31) begin nw = 0; return (s + e) / 2; end
        s = e + 1;
      end
    end
    nw = 1;
    return 0;
  endfunction

  task automatic run_cal(string tag);
    bit nw, busy_bad;
    int ex;
    busy_bad = 0;
    @(negedge clk) clr_mon = 1'b1;
    @(negedge clk) begin clr_mon = 1'b0; start = 1'b1; end
    @(negedge clk) start = 1'b0;
    while (!done) begin
      if (!busy) busy_bad = 1;
      @(negedge clk);
    end
    ex = exp_pick(nw);
    chk(vdly_ok, "R1 validation delay cleared first", int'(vdly_ok), 1);
    chk(rx_wr == 33 && seq_bad == 0, "R2 sweep order", rx_wr, 33);
    chk(pair_bad == 0, "R3 measurement pairs per code", pair_bad, 0);
    chk(!busy_bad && !busy && done, "R8 busy until done", int'(busy), 0);
    chk(int'(delay_code) == ex, {tag, " chosen code"}, int'(delay_code), ex);
    chk(final_data == ex, "R5 final register write", final_data, ex);
    chk(no_window == nw, "R7 no window flag", int'(no_window), int'(nw));
    for (int i = 0; i < 32; i++) begin
      @(negedge clk) stat_idx = 5'(i);
      @(negedge clk);
      chk(stat_cls == prof[i], "R4 status grade", int'(stat_cls), int'(prof[i]));
    end
  endtask

  initial begin
    stat_idx = '0;
    for (int i = 0; i < 32; i++) prof[i] = P;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !no_window && !reg_wr && delay_code == 0, "R9 reset state",
        int'({busy, done, no_window, reg_wr}), 0);

    // Run at 0 ineligible; first bounded window 6..10 -> 8
    for (int i = 0; i < 32; i++) prof[i] = P;
    foreach (prof[i]) if (i inside {4, 5, 11, 12, 20, 21, 22, 28, 29}) prof[i] = M;
    run_cal("R6 R5 zero-anchored run skipped");
    // Even window 3..6 rounds down -> 4
    for (int i = 0; i < 32; i++) prof[i] = (i >= 3 && i <= 6) ? P : F;
    run_cal("R5 even window");
    // Single-code window at 1
    for (int i = 0; i < 32; i++) prof[i] = (i == 1) ? P : ((i == 0) ? F : M);
    run_cal("R5 one-code window");
    // Pass run reaching 31 only
    for (int i = 0; i < 32; i++) prof[i] = (i >= 20) ? P : F;
    run_cal("R6 top-anchored run");
    // All pass
    for (int i = 0; i < 32; i++) prof[i] = P;
    run_cal("R7 all pass");
    // All fail
    for (int i = 0; i < 32; i++) prof[i] = F;
    run_cal("R7 all fail");
    // Random profiles
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 32; i++) begin
        int v;
        v = int'($urandom_range(0, 9));
        prof[i] = (v < 6) ? P : ((v < 8) ? F : M);
      end
      run_cal("R5 random profile");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule